// File: doc/BRIEF.md
# TDM Receive Time-Slot Classifier

This block sits behind a TDM deserializer. Each received byte arrives with the number of the time slot it occupied in its frame. A per-slot class table decides where the byte goes. Voice bytes and 56K-mode bytes go to one shared voice buffer. An HDLC byte goes to one of four HDLC buffers, chosen by the slot's buffer index. A byte in an unassigned slot is dropped. Each buffer packs its bytes little-endian into 32-bit words and hands them downstream two words at a time. Each buffer holds two halves in ping-pong fashion, so one half fills while the other waits to be read.

The byte input has a valid/ready interface, but `in_ready` is always high and the input never applies back-pressure. A buffer that has no room drops the incoming byte and raises its own sticky overflow flag. Each buffer output is a separate valid/ready stream. A presented pair of words stays fixed until the consumer takes it, and it moves on the cycle in which valid and ready are both high.

A host writes a shadow copy of the class table. The shadow copy becomes the active table when the next slot-0 byte arrives. Every frame is therefore classified with one consistent set of entries.

Top module: `tdm_slot_sorter`

## Requirements
- R1: A byte in a slot of class 2 (voice) or class 3 (56K mode) is written to buffer 0, the voice buffer.
- R2: A byte in a slot of class 1 (HDLC) is written to buffer 1+h, where h is the slot's 2-bit HDLC index (0..3). No other buffer receives it.
- R3: A byte in a slot of class 0 (unassigned) is written to no buffer. It does not change the contents of any buffer.
- R4: Eight bytes make one hand-off. The first byte lands in bits [7:0] of the 64-bit `out_data` lane and the eighth byte in bits [63:56]. The first 32-bit word is bits [31:0].
- R5: While a buffer's `out_valid` is high and its `out_ready` is low, `out_valid` stays high and the lane data does not change. One pair is consumed in a cycle where both are high.
- R6: Each buffer has two halves. After one half is complete, writing continues into the other half. Completed pairs are delivered in the order they were filled.
- R7: If both halves of the target buffer are complete when a byte arrives, that byte is dropped and the buffer's `overflow` bit is set. The bit stays set until reset. Dropped bytes never appear in later output.
- R8: A table write takes effect starting with the next slot-0 byte, and that byte is the first one it applies to. Bytes before that byte use the previous entry. A write made in the same cycle as a slot-0 byte takes effect at the slot-0 byte after that.
- R9: After reset every table entry is unassigned, no `out_valid` is high and every `overflow` bit is clear.
- R10: `in_ready` is high at all times after reset. The input is never stalled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A received byte is present |
| in_ready | output | 1 | Always high; the block never stalls the input |
| in_slot | input | SLOT_W (5) | Time slot of the byte within its frame |
| in_byte | input | BYTE_W (8) | Received byte |
| cfg_we | input | 1 | Write one shadow table entry |
| cfg_slot | input | SLOT_W (5) | Slot whose entry is written |
| cfg_class | input | 2 | 0 unassigned, 1 HDLC, 2 voice, 3 56K mode |
| cfg_hdlc | input | 2 | HDLC buffer index for class 1 |
| out_valid | output | NBUF (5) | Per buffer: a pair of words is available |
| out_ready | input | NBUF (5) | Per buffer: the consumer takes the pair |
| out_data | output | NBUF*64 (320) | Buffer b uses bits [64*b+63:64*b] |
| overflow | output | NBUF (5) | Per buffer sticky drop flag |

## Verification
The hardest state to reach from the ports is the overflow case, where both halves of one buffer hold complete pairs and further bytes arrive for that buffer. The bench holds that buffer's ready low while sixteen bytes are sent to one HDLC slot, then sends extra bytes. It then drains both pairs and checks that the dropped bytes never appear. The deferred table update is the other hard case. The bench rewrites a slot's class in the middle of a frame and checks that the old routing holds until a slot-0 byte arrives.

// File: rtl/tdm_sort_pkg.sv
package tdm_sort_pkg;

  localparam int HIDX_W   = 2;
  localparam int NUM_HDLC = 1 << HIDX_W;
  localparam int NBUF     = 1 + NUM_HDLC;

  typedef enum logic [1:0] {
    CLS_IDLE  = 2'd0,
    CLS_HDLC  = 2'd1,
    CLS_VOICE = 2'd2,
    CLS_V56   = 2'd3
  } slot_class_e;

  typedef struct packed {
    slot_class_e        cls;
    logic [HIDX_W-1:0]  hidx;
  } slot_cfg_t;

endpackage

// File: rtl/slot_table.sv
module slot_table
  import tdm_sort_pkg::*;
#(
  parameter int NUM_SLOTS = 32,
  localparam int SLOT_W   = $clog2(NUM_SLOTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [SLOT_W-1:0] cfg_slot,
  input  slot_cfg_t         cfg_entry,
  input  logic              lk_valid,
  input  logic [SLOT_W-1:0] lk_slot,
  output slot_cfg_t         lk_entry
);

  localparam int TBL_DEPTH = 1 << SLOT_W;

  slot_cfg_t [TBL_DEPTH-1:0] shadow_q;
  slot_cfg_t [TBL_DEPTH-1:0] active_q;
  logic                      frame_start;

  assign frame_start = lk_valid && (lk_slot == '0);

  // Host writes land in the shadow copy only.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shadow_q <= '0;
    end else if (cfg_we) begin
      shadow_q[cfg_slot] <= cfg_entry;
    end
  end

  // The whole shadow copy is promoted when a slot-0 byte arrives.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q <= '0;
    end else if (frame_start) begin
      active_q <= shadow_q;
    end
  end

  // A slot-0 byte already uses the entries that are being promoted.
  always_comb begin
    if (lk_slot == '0) lk_entry = shadow_q[0];
    else               lk_entry = active_q[lk_slot];
  end

  assert_cfg_defer_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start |=> $stable(active_q))
    else $error("active table changed outside a frame start");

endmodule

// File: rtl/byte_pingpong.sv
module byte_pingpong #(
  parameter int BYTE_W = 8,
  parameter int WORD_W = 32,
  parameter int WORDS  = 2,
  localparam int HALF_W = WORD_W * WORDS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [BYTE_W-1:0] wr_byte,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [HALF_W-1:0] out_data,
  output logic              ovf
);

  localparam int BYTES = HALF_W / BYTE_W;
  localparam int POS_W = $clog2(BYTES);

  logic [1:0][HALF_W-1:0] half_q;
  logic [1:0]             full_q;
  logic                   wr_sel_q;
  logic                   rd_sel_q;
  logic [POS_W-1:0]       pos_q;
  logic                   ovf_q;
  logic                   pop;
  logic                   accept;
  logic                   reject;
  logic                   last_byte;

  assign pop       = full_q[rd_sel_q] && out_ready;
  assign accept    = wr_en && !full_q[wr_sel_q];
  assign reject    = wr_en &&  full_q[wr_sel_q];
  assign last_byte = (pos_q == POS_W'(BYTES - 1));

  // Byte lanes are filled lowest first within the open half.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      half_q <= '0;
    end else if (accept) begin
      half_q[wr_sel_q][pos_q*BYTE_W +: BYTE_W] <= wr_byte;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full_q   <= '0;
      wr_sel_q <= 1'b0;
      rd_sel_q <= 1'b0;
      pos_q    <= '0;
    end else begin
      if (pop) begin
        full_q[rd_sel_q] <= 1'b0;
        rd_sel_q         <= ~rd_sel_q;
      end
      if (accept) begin
        if (last_byte) begin
          full_q[wr_sel_q] <= 1'b1;
          wr_sel_q         <= ~wr_sel_q;
          pos_q            <= '0;
        end else begin
          pos_q <= pos_q + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      ovf_q <= 1'b0;
    else if (reject) ovf_q <= 1'b1;
  end

  assign out_valid = full_q[rd_sel_q];
  assign out_data  = half_q[rd_sel_q];
  assign ovf       = ovf_q;

  assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data))
    else $error("pair changed while stalled");

  assert_pp_align_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (&full_q) |-> (wr_sel_q == rd_sel_q))
    else $error("both halves full but pointers differ");

  assert_drop_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && (&full_q) |=> ovf)
    else $error("drop did not raise overflow");

  assert_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> ovf)
    else $error("overflow flag cleared");

endmodule

// File: rtl/tdm_slot_sorter.sv
module tdm_slot_sorter
  import tdm_sort_pkg::*;
#(
  parameter int NUM_SLOTS      = 32,
  parameter int BYTE_W         = 8,
  parameter int WORD_W         = 32,
  parameter int WORDS_PER_XFER = 2,
  localparam int SLOT_W        = $clog2(NUM_SLOTS),
  localparam int HALF_W        = WORD_W * WORDS_PER_XFER,
  localparam int NB            = NBUF
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [SLOT_W-1:0]    in_slot,
  input  logic [BYTE_W-1:0]    in_byte,
  input  logic                 cfg_we,
  input  logic [SLOT_W-1:0]    cfg_slot,
  input  logic [1:0]           cfg_class,
  input  logic [HIDX_W-1:0]    cfg_hdlc,
  output logic [NB-1:0]        out_valid,
  input  logic [NB-1:0]        out_ready,
  output logic [NB*HALF_W-1:0] out_data,
  output logic [NB-1:0]        overflow
);

  slot_cfg_t     cfg_entry;
  slot_cfg_t     lk_entry;
  logic [NB-1:0] wr_en;

  assign cfg_entry.cls  = slot_class_e'(cfg_class);
  assign cfg_entry.hidx = cfg_hdlc;
  assign in_ready       = 1'b1;

  slot_table #(.NUM_SLOTS(NUM_SLOTS)) u_table (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_we   (cfg_we),
    .cfg_slot (cfg_slot),
    .cfg_entry(cfg_entry),
    .lk_valid (in_valid),
    .lk_slot  (in_slot),
    .lk_entry (lk_entry)
  );

  // Steering: voice and 56K share buffer 0, HDLC picks 1 + index.
  always_comb begin
    wr_en = '0;
    if (in_valid) begin
      unique case (lk_entry.cls)
        CLS_VOICE, CLS_V56: wr_en[0] = 1'b1;
        CLS_HDLC: begin
          for (int h = 0; h < NUM_HDLC; h++) begin
            if (lk_entry.hidx == HIDX_W'(h)) wr_en[1+h] = 1'b1;
          end
        end
        default: wr_en = '0;
      endcase
    end
  end

  for (genvar g = 0; g < NB; g++) begin : g_buf
    byte_pingpong #(
      .BYTE_W(BYTE_W),
      .WORD_W(WORD_W),
      .WORDS (WORDS_PER_XFER)
    ) u_pp (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en[g]),
      .wr_byte  (in_byte),
      .out_valid(out_valid[g]),
      .out_ready(out_ready[g]),
      .out_data (out_data[g*HALF_W +: HALF_W]),
      .ovf      (overflow[g])
    );
  end

  assert_one_target_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_en))
    else $error("byte steered to more than one buffer");

  assert_idle_drop_R3: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && (lk_entry.cls == CLS_IDLE) && (out_ready == '0) |=> $stable(out_valid))
    else $error("unassigned byte changed a buffer");

endmodule

// File: tb/tdm_slot_sorter_tb.sv
`timescale 1ns/1ps
module tdm_slot_sorter_tb;

  localparam int NB = 5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [4:0]    in_slot = '0;
  logic [7:0]    in_byte = '0;
  logic          cfg_we = 1'b0;
  logic [4:0]    cfg_slot = '0;
  logic [1:0]    cfg_class = '0;
  logic [1:0]    cfg_hdlc = '0;
  logic [NB-1:0] out_valid;
  logic [NB-1:0] out_ready = '0;
  logic [NB*64-1:0] out_data;
  logic [NB-1:0] overflow;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #2 clk = ~clk;

  tdm_slot_sorter u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_slot(in_slot), .in_byte(in_byte), .cfg_we(cfg_we), .cfg_slot(cfg_slot),
    .cfg_class(cfg_class), .cfg_hdlc(cfg_hdlc), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .overflow(overflow)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] seq8(input logic [7:0] base);
    logic [63:0] v;
    for (int i = 0; i < 8; i++) v[i*8 +: 8] = base + 8'(i);
    return v;
  endfunction

  function automatic logic [63:0] lane(input int b);
    return out_data[b*64 +: 64];
  endfunction

  task automatic send(input logic [4:0] s, input logic [7:0] d);
    in_valid = 1'b1; in_slot = s; in_byte = d;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic cfg(input logic [4:0] s, input logic [1:0] c, input logic [1:0] h);
    cfg_we = 1'b1; cfg_slot = s; cfg_class = c; cfg_hdlc = h;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic pop(input int b);
    out_ready = NB'(1) << b;
    @(negedge clk);
    out_ready = '0;
  endtask

  task automatic t_reset();
    check("R9 no valid after reset", 64'(out_valid), 64'h0);
    check("R9 overflow clear after reset", 64'(overflow), 64'h0);
    check("R10 in_ready high", 64'(in_ready), 64'h1);
  endtask

  task automatic t_reset_table();
    for (int i = 0; i < 8; i++) send(5'(i), 8'h10 + 8'(i));
    check("R9 reset table routes nothing", 64'(out_valid), 64'h0);
  endtask

  task automatic t_voice56();
    cfg(5'd0, 2'd2, 2'd0);
    cfg(5'd1, 2'd3, 2'd0);
    for (int i = 0; i < 8; i++) send(5'(i % 2), 8'hA0 + 8'(i));
    check("R1 voice and 56K fill buffer 0", 64'(out_valid), 64'h01);
    check("R4 little-endian pair", lane(0), seq8(8'hA0));
    check("R4 first word in low bits", 64'(lane(0)[31:0]), 64'hA3A2A1A0);
    check("R10 in_ready high while streaming", 64'(in_ready), 64'h1);
    pop(0);
    check("R5 pair consumed on handshake", 64'(out_valid), 64'h0);
  endtask

  task automatic t_hdlc();
    cfg(5'd2, 2'd1, 2'd2);
    cfg(5'd3, 2'd1, 2'd0);
    cfg(5'd4, 2'd0, 2'd1);
    send(5'd0, 8'hC0);
    for (int i = 0; i < 8; i++) begin
      send(5'd2, 8'h20 + 8'(i));
      send(5'd3, 8'h30 + 8'(i));
      send(5'd4, 8'hEE);
    end
    check("R2 HDLC index picks buffers 1 and 3 only", 64'(out_valid), 64'h0A);
    check("R2 buffer 3 data", lane(3), seq8(8'h20));
    check("R3 unassigned bytes absent from buffer 1", lane(1), seq8(8'h30));
    pop(1);
    pop(3);
    for (int i = 1; i < 8; i++) send(5'd1, 8'hC0 + 8'(i));
    check("R1 56K bytes join voice buffer", 64'(out_valid), 64'h01);
    check("R1 voice buffer data", lane(0), seq8(8'hC0));
    pop(0);
    check("R3 nothing pending", 64'(out_valid), 64'h0);
  endtask

  task automatic t_hold();
    for (int i = 0; i < 8; i++) send(5'd2, 8'h50 + 8'(i));
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      check("R5 valid held while stalled", 64'(out_valid[3]), 64'h1);
      check("R5 data held while stalled", lane(3), seq8(8'h50));
    end
    pop(3);
    check("R5 released after handshake", 64'(out_valid), 64'h0);
  endtask

  task automatic t_overflow();
    for (int i = 0; i < 16; i++) send(5'd2, 8'h60 + 8'(i));
    check("R6 first pair presented", lane(3), seq8(8'h60));
    check("R7 no overflow with both halves just full", 64'(overflow), 64'h0);
    for (int i = 0; i < 3; i++) send(5'd2, 8'hF0 + 8'(i));
    check("R7 overflow flag on drop", 64'(overflow), 64'h08);
    pop(3);
    check("R6 second half follows", 64'(out_valid[3]), 64'h1);
    check("R6 second pair data", lane(3), seq8(8'h68));
    pop(3);
    check("R6 drained", 64'(out_valid), 64'h0);
    check("R7 overflow sticky", 64'(overflow), 64'h08);
    for (int i = 0; i < 8; i++) send(5'd2, 8'h70 + 8'(i));
    check("R7 dropped bytes never appear", lane(3), seq8(8'h70));
    pop(3);
  endtask

  task automatic t_frame_boundary();
    cfg(5'd2, 2'd2, 2'd0);
    for (int i = 0; i < 8; i++) send(5'd2, 8'h80 + 8'(i));
    check("R8 old routing until slot 0", 64'(out_valid), 64'h08);
    check("R8 old routing data", lane(3), seq8(8'h80));
    pop(3);
    send(5'd0, 8'h90);
    for (int i = 1; i < 8; i++) send(5'd2, 8'h90 + 8'(i));
    check("R8 new routing from slot 0", 64'(out_valid), 64'h01);
    check("R8 new routing data", lane(0), seq8(8'h90));
    pop(0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_reset_table();
    t_voice56();
    t_hdlc();
    t_hold();
    t_overflow();
    t_frame_boundary();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule